// File: doc/BRIEF.md
# Critical-Word-First Instruction Line Fill Unit

This unit handles instruction-cache misses. Each miss address is placed in a small fetch queue, two entries deep by default. For each queued miss the unit sends one line request to memory. The memory then returns the eight 32-bit words of the line as a stream of beats. The stream starts at the word that missed and wraps around the end of the line. The unit places each beat in its correct slot in a line buffer.

The first beat of a line is the word the core is waiting for. It is passed to the core in the same cycle that it is accepted, so the core does not wait for the rest of the line. When the eighth beat arrives, the unit presents the whole line on a write port for one cycle, with an even-parity bit for each word, and frees the queue entry.

While fills are pending, the core may keep fetching from the cache. A lookup input reports whether a given address falls in a line that is still waiting for its fill. An instruction in such a line must wait, and any other instruction may go ahead.

Top module: `icache_cwf_fill`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `q_count` is 0, `miss_ready` is 1, and `mem_req_valid`, `beat_ready`, `crit_valid` and `line_wr_en` are 0.
- R2: A miss is taken on a clock edge where `miss_valid` and `miss_ready` are both high. `miss_ready` is low while `q_count` equals the queue depth (2). A miss offered while the queue is full is dropped and does not change `q_count`.
- R3: One memory request is made for each queued miss, in arrival order. Each request is held until `mem_req_ready` is high. `mem_req_addr` is the miss address with bits [1:0] forced to zero.
- R4: For a line whose miss address has bits [4:2] equal to c, beat k (k = 0..7) fills word (c+k) mod 8 of the line.
- R5: In the cycle that beat 0 of a line is accepted, `crit_valid` is high. In that cycle `crit_data` equals `beat_data`, and `crit_addr` equals the miss address with bits [1:0] zero. `crit_valid` is low for every other beat.
- R6: In the cycle after beat 7 is accepted, `line_wr_en` is high for exactly one cycle and `line_wr_tag` equals miss address bits [31:5]. In that cycle, word i of the line is at `line_wr_data[32i+31:32i]`, and `q_count` has dropped by one.
- R7: `line_wr_par[i]` is the XOR of the 32 bits of word i, so that word i together with its parity bit has an even number of ones.
- R8: `beat_ready` is high only while the oldest queued miss has had its request accepted. Beats offered at any other time are not taken and have no effect.
- R9: `lookup_busy` is high, in the same cycle, exactly when `lookup_addr` bits [31:5] match a miss that is still queued.
- R10: A second queued line can be filled starting in the cycle right after the first line's last beat, with no idle cycle between them. Each line is still assembled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss address offered |
| miss_ready | output | 1 | Queue can take a miss |
| miss_addr | input | 32 | Byte address of the missing instruction |
| lookup_addr | input | 32 | Address the core wants to fetch |
| lookup_busy | output | 1 | Lookup address lies in a line still being filled |
| mem_req_valid | output | 1 | Line request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 32 | Critical word address of the request |
| beat_valid | input | 1 | Memory beat present |
| beat_ready | output | 1 | Unit takes the beat |
| beat_data | input | 32 | Beat word |
| crit_valid | output | 1 | Critical word forwarded to core |
| crit_addr | output | 32 | Address of the forwarded word |
| crit_data | output | 32 | Forwarded word |
| line_wr_en | output | 1 | Line write strobe |
| line_wr_tag | output | 27 | Line address of the write |
| line_wr_data | output | 256 | Assembled line, word i at bits [32i+31:32i] |
| line_wr_par | output | 8 | Even parity per word |
| q_count | output | 2 | Number of queued misses |

## Verification
If the unit starts a line at the wrong offset, the error shows at the line write port in the cycle after the eighth beat. Every word lands in the wrong slot, and the parity bits still agree with the misplaced words. For this reason the bench gives each word a distinct value and checks the whole line.

An error in the beat counter first shows as a missing or extra `crit_valid` pulse on the next line. An error in the queue pointers shows as a request carrying the wrong address, or as `beat_ready` rising before that line's request has been accepted. Each of these appears within a single handshake of the error.

// File: rtl/ilf_pkg.sv
`timescale 1ns/1ps
package ilf_pkg;
  localparam int unsigned ILF_ADDR_W = 32;
  localparam int unsigned ILF_WORD_W = 32;
  localparam int unsigned ILF_LINE_WORDS = 8;
  localparam int unsigned ILF_QDEPTH = 2;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ilf_miss_queue.sv
`timescale 1ns/1ps
module ilf_miss_queue #(
  parameter int unsigned WA_W  = 30,
  parameter int unsigned IW    = 3,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW   = ilf_pkg::ptr_w(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned TW   = WA_W - IW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  output logic            push_ready,
  input  logic [WA_W-1:0] push_wa,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [WA_W-1:0] req_wa,
  output logic            head_issued,
  output logic [WA_W-1:0] head_wa,
  input  logic            pop,
  output logic [CW-1:0]   count,
  input  logic [TW-1:0]   look_tag,
  output logic            look_hit
);
  logic [WA_W-1:0]  slots [DEPTH];
  logic [DEPTH-1:0] held;
  logic [PW-1:0]    rd_ptr, wr_ptr, iss_ptr;
  logic [CW-1:0]    iss_cnt;
  logic             push_fire, req_fire;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign push_ready  = (count != CW'(DEPTH));
  assign push_fire   = push_valid && push_ready;
  assign req_valid   = (iss_cnt < count);
  assign req_fire    = req_valid && req_ready;
  assign req_wa      = slots[iss_ptr];
  assign head_wa     = slots[rd_ptr];
  assign head_issued = (iss_cnt != '0);

  always_ff @(posedge clk) begin
    if (push_fire) slots[wr_ptr] <= push_wa;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      iss_ptr <= '0;
      count   <= '0;
      iss_cnt <= '0;
    end else begin
      if (push_fire) begin
        held[wr_ptr] <= 1'b1;
        wr_ptr       <= step(wr_ptr);
      end
      if (pop) begin
        held[rd_ptr] <= 1'b0;
        rd_ptr       <= step(rd_ptr);
      end
      if (req_fire) iss_ptr <= step(iss_ptr);
      count   <= count + CW'(push_fire) - CW'(pop);
      iss_cnt <= iss_cnt + CW'(req_fire) - CW'(pop);
    end
  end

  always_comb begin
    look_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (held[i] && slots[i][WA_W-1:IW] == look_tag) look_hit = 1'b1;
    end
  end

  // R2: occupancy never exceeds the queue depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R3: never more requests outstanding than queued misses
  a_r3_issue_bound: assert property (@(posedge clk) disable iff (rst)
    iss_cnt <= count);
  // R8: a line retires only after its request was accepted
  a_r8_pop_issued: assert property (@(posedge clk) disable iff (rst)
    pop |-> iss_cnt != '0);
endmodule

// File: rtl/ilf_line_asm.sv
`timescale 1ns/1ps
module ilf_line_asm #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned TAG_W      = 27,
  localparam int unsigned IW        = $clog2(LINE_WORDS),
  localparam int unsigned LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_fire,
  input  logic [WORD_W-1:0] beat_data,
  input  logic [IW-1:0]     crit_idx,
  input  logic [TAG_W-1:0]  line_tag,
  output logic              first_beat,
  output logic              last_beat,
  output logic              wr_en,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] wr_data,
  output logic [LINE_WORDS-1:0] wr_par
);
  logic [WORD_W-1:0]     words [LINE_WORDS];
  logic [IW-1:0]         beat_cnt;
  logic [IW-1:0]         slot;
  logic [LINE_W-1:0]     merged;
  logic [LINE_WORDS-1:0] merged_par;

  assign slot       = crit_idx + beat_cnt;
  assign first_beat = (beat_cnt == '0);
  assign last_beat  = (beat_cnt == IW'(LINE_WORDS - 1));

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_merge
    assign merged[i*WORD_W +: WORD_W] =
      (beat_fire && slot == IW'(i)) ? beat_data : words[i];
    assign merged_par[i] = ^merged[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (beat_fire) words[slot] <= beat_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt <= '0;
      wr_en    <= 1'b0;
      wr_tag   <= '0;
      wr_data  <= '0;
      wr_par   <= '0;
    end else begin
      wr_en <= beat_fire && last_beat;
      if (beat_fire) beat_cnt <= last_beat ? '0 : beat_cnt + IW'(1);
      if (beat_fire && last_beat) begin
        wr_tag  <= line_tag;
        wr_data <= merged;
        wr_par  <= merged_par;
      end
    end
  end

  // R6: a line write follows the final beat of a line
  a_r6_write_after_last: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(beat_fire && last_beat));
  // R6: the write strobe lasts a single cycle
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/icache_cwf_fill.sv
`timescale 1ns/1ps
module icache_cwf_fill #(
  parameter int unsigned ADDR_W     = ilf_pkg::ILF_ADDR_W,
  parameter int unsigned WORD_W     = ilf_pkg::ILF_WORD_W,
  parameter int unsigned LINE_WORDS = ilf_pkg::ILF_LINE_WORDS,
  parameter int unsigned QDEPTH     = ilf_pkg::ILF_QDEPTH,
  localparam int unsigned BOFF      = $clog2(WORD_W / 8),
  localparam int unsigned IW        = $clog2(LINE_WORDS),
  localparam int unsigned OFF_W     = IW + BOFF,
  localparam int unsigned TAG_W     = ADDR_W - OFF_W,
  localparam int unsigned WA_W      = ADDR_W - BOFF,
  localparam int unsigned LINE_W    = WORD_W * LINE_WORDS,
  localparam int unsigned CW        = $clog2(QDEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  output logic                  miss_ready,
  input  logic [ADDR_W-1:0]     miss_addr,
  input  logic [ADDR_W-1:0]     lookup_addr,
  output logic                  lookup_busy,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  beat_valid,
  output logic                  beat_ready,
  input  logic [WORD_W-1:0]     beat_data,
  output logic                  crit_valid,
  output logic [ADDR_W-1:0]     crit_addr,
  output logic [WORD_W-1:0]     crit_data,
  output logic                  line_wr_en,
  output logic [TAG_W-1:0]      line_wr_tag,
  output logic [LINE_W-1:0]     line_wr_data,
  output logic [LINE_WORDS-1:0] line_wr_par,
  output logic [CW-1:0]         q_count
);
  logic [WA_W-1:0] req_wa, head_wa;
  logic            head_issued, beat_fire, first_beat, last_beat;
  logic            unused_low;

  assign unused_low = ^{miss_addr[BOFF-1:0], lookup_addr[OFF_W-1:0]};

  ilf_miss_queue #(.WA_W(WA_W), .IW(IW), .DEPTH(QDEPTH)) u_queue (
    .clk         (clk),
    .rst         (rst),
    .push_valid  (miss_valid),
    .push_ready  (miss_ready),
    .push_wa     (miss_addr[ADDR_W-1:BOFF]),
    .req_valid   (mem_req_valid),
    .req_ready   (mem_req_ready),
    .req_wa      (req_wa),
    .head_issued (head_issued),
    .head_wa     (head_wa),
    .pop         (beat_fire && last_beat),
    .count       (q_count),
    .look_tag    (lookup_addr[ADDR_W-1:OFF_W]),
    .look_hit    (lookup_busy)
  );

  assign beat_ready   = head_issued;
  assign beat_fire    = beat_valid && beat_ready;
  assign mem_req_addr = {req_wa, {BOFF{1'b0}}};
  assign crit_valid   = beat_fire && first_beat;
  assign crit_data    = beat_data;
  assign crit_addr    = {head_wa, {BOFF{1'b0}}};

  ilf_line_asm #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .beat_fire  (beat_fire),
    .beat_data  (beat_data),
    .crit_idx   (head_wa[IW-1:0]),
    .line_tag   (head_wa[WA_W-1:IW]),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .wr_en      (line_wr_en),
    .wr_tag     (line_wr_tag),
    .wr_data    (line_wr_data),
    .wr_par     (line_wr_par)
  );

  // R5: the critical word is forwarded once per line, never on consecutive beats
  a_r5_crit_isolated: assert property (@(posedge clk) disable iff (rst)
    crit_valid |=> !crit_valid);
  // R6: a line write frees one queue entry
  a_r6_count_drop: assert property (@(posedge clk) disable iff (rst)
    line_wr_en |-> q_count == $past(q_count) - CW'(1) + CW'($past(miss_valid && miss_ready)));
  // R8: no beat is taken while nothing is queued
  a_r8_beat_needs_entry: assert property (@(posedge clk) disable iff (rst)
    beat_ready |-> q_count != '0);
  // R7: every written word carries even parity
  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_par_chk
    a_r7_even_parity: assert property (@(posedge clk) disable iff (rst)
      line_wr_en |-> line_wr_par[i] == ^line_wr_data[i*WORD_W +: WORD_W]);
  end
endmodule

// File: tb/icache_cwf_fill_test.sv
`timescale 1ns/1ps
module icache_cwf_fill_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         miss_valid = 1'b0;
  logic         miss_ready;
  logic [31:0]  miss_addr = '0;
  logic [31:0]  lookup_addr = '0;
  logic         lookup_busy;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         beat_valid = 1'b0;
  logic         beat_ready;
  logic [31:0]  beat_data = '0;
  logic         crit_valid;
  logic [31:0]  crit_addr;
  logic [31:0]  crit_data;
  logic         line_wr_en;
  logic [26:0]  line_wr_tag;
  logic [255:0] line_wr_data;
  logic [7:0]   line_wr_par;
  logic [1:0]   q_count;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  icache_cwf_fill uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .lookup_addr(lookup_addr), .lookup_busy(lookup_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .crit_valid(crit_valid), .crit_addr(crit_addr),
    .crit_data(crit_data), .line_wr_en(line_wr_en), .line_wr_tag(line_wr_tag),
    .line_wr_data(line_wr_data), .line_wr_par(line_wr_par), .q_count(q_count)
  );

  // miss address, data seed
  localparam logic [63:0] VEC [8] = '{
    {32'h0000_1000, 32'h0000_0000},
    {32'h0000_2044, 32'hFFFF_FFFF},
    {32'h1234_567C, 32'hA5A5_5A5A},
    {32'h8000_0030, 32'h0F0F_F0F0},
    {32'h0ABC_DE08, 32'h1357_2468},
    {32'hFFFF_FFF4, 32'h8000_0001},
    {32'h4000_0118, 32'h7FFF_FFFE},
    {32'h0000_004E, 32'hDEAD_BEEF}
  };

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int w);
    return (seed ^ (32'(w) * 32'h1357_9BDF)) + 32'(w);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic exp_ready);
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    #1 chk("R2", "miss_ready", 256'(miss_ready), 256'(exp_ready));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic issue(input logic [31:0] a);
    #1 chk("R3", "mem_req_valid", 256'(mem_req_valid), 256'(1'b1));
    chk("R3", "mem_req_addr", 256'(mem_req_addr), 256'({a[31:2], 2'b00}));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
  endtask

  // drives eight beats, returns at the negedge after the last accepted beat
  task automatic beats(input logic [31:0] a, input logic [31:0] seed);
    for (int k = 0; k < 8; k++) begin
      int w;
      w = (int'(a[4:2]) + k) % 8;
      beat_valid = 1'b1;
      beat_data  = word_of(seed, w);
      #1 chk("R8", "beat_ready", 256'(beat_ready), 256'(1'b1));
      chk("R5", "crit_valid", 256'(crit_valid), 256'(k == 0));
      if (k == 0) begin
        chk("R5", "crit_data", 256'(crit_data), 256'(word_of(seed, w)));
        chk("R5", "crit_addr", 256'(crit_addr), 256'({a[31:2], 2'b00}));
      end
      if (k == 3) begin
        lookup_addr = {a[31:5], 5'h1C};
        #1 chk("R9", "lookup_busy same line", 256'(lookup_busy), 256'(1'b1));
        lookup_addr = a ^ 32'h0000_0020;
        #1 chk("R9", "lookup_busy other line", 256'(lookup_busy), 256'(1'b0));
      end
      @(negedge clk);
    end
  endtask

  task automatic check_line(input logic [31:0] a, input logic [31:0] seed,
                            input logic [1:0] exp_cnt);
    logic [255:0] exp_data;
    logic [7:0]   exp_par;
    for (int i = 0; i < 8; i++) begin
      exp_data[i*32 +: 32] = word_of(seed, i);
      exp_par[i] = ^word_of(seed, i);
    end
    #1 chk("R6", "line_wr_en", 256'(line_wr_en), 256'(1'b1));
    chk("R6", "line_wr_tag", 256'(line_wr_tag), 256'(a[31:5]));
    chk("R4", "line_wr_data", line_wr_data, exp_data);
    chk("R7", "line_wr_par", 256'(line_wr_par), 256'(exp_par));
    chk("R6", "q_count after write", 256'(q_count), 256'(exp_cnt));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    #1 chk("R1", "q_count in reset", 256'(q_count), 256'(0));
    chk("R1", "miss_ready in reset", 256'(miss_ready), 256'(1'b1));
    chk("R1", "mem_req_valid in reset", 256'(mem_req_valid), 256'(1'b0));
    chk("R1", "line_wr_en in reset", 256'(line_wr_en), 256'(1'b0));
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 chk("R1", "beat_ready after reset", 256'(beat_ready), 256'(1'b0));
    chk("R1", "crit_valid after reset", 256'(crit_valid), 256'(1'b0));

    // table of fills, one line at a time
    for (int v = 0; v < 8; v++) begin
      logic [31:0] a, s;
      a = VEC[v][63:32];
      s = VEC[v][31:0];
      push(a, 1'b1);
      issue(a);
      beats(a, s);
      beat_valid = 1'b0;
      check_line(a, s, 2'd0);
      @(negedge clk);
      #1 chk("R6", "line_wr_en pulse ends", 256'(line_wr_en), 256'(1'b0));
    end

    // R8: beats before the request is accepted are ignored
    push(32'h0000_3014, 1'b1);
    beat_valid = 1'b1;
    beat_data  = 32'hBAD0_BAD0;
    #1 chk("R8", "beat_ready before request", 256'(beat_ready), 256'(1'b0));
    chk("R8", "crit_valid before request", 256'(crit_valid), 256'(1'b0));
    @(negedge clk);
    beat_valid = 1'b0;
    #1 chk("R8", "line_wr_en after ignored beat", 256'(line_wr_en), 256'(1'b0));

    // R2: second miss fills the queue, third is refused
    push(32'h0000_5068, 1'b1);
    #1 chk("R2", "q_count full", 256'(q_count), 256'(2));
    lookup_addr = 32'h0000_5060;
    #1 chk("R9", "lookup_busy second entry", 256'(lookup_busy), 256'(1'b1));
    lookup_addr = 32'h0000_7060;
    #1 chk("R9", "lookup_busy idle line", 256'(lookup_busy), 256'(1'b0));
    push(32'h0000_9000, 1'b0);
    #1 chk("R2", "q_count after refused miss", 256'(q_count), 256'(2));

    // R3: requests in arrival order
    issue(32'h0000_3014);
    issue(32'h0000_5068);
    #1 chk("R3", "no further request", 256'(mem_req_valid), 256'(1'b0));

    // R10: two lines back to back; the ignored beat left no trace (R8)
    beats(32'h0000_3014, 32'h2222_0000);
    check_line(32'h0000_3014, 32'h2222_0000, 2'd1);
    beats(32'h0000_5068, 32'h3333_1111);
    beat_valid = 1'b0;
    check_line(32'h0000_5068, 32'h3333_1111, 2'd0);
    chk("R10", "queue ready after pair", 256'(miss_ready), 256'(1'b1));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule